// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches the upper pins of a general-purpose input port and flags any pin that has moved away from the value software last saw. A snapshot register holds the pin values captured at the most recent port read or port write. While a monitored input pin differs from its snapshot bit, a sticky change flag is raised. It is raised again on every cycle for as long as the difference lasts.

Software services the interrupt in a fixed order. It first reads or writes the port, which reloads the whole snapshot at once and so removes the difference. It then clears the flag. A clear issued while a difference is still present has no lasting effect. The snapshot is not part of the reset network, so a difference that exists across a reset raises the flag as soon as reset is released. Pins are brought into the clock domain through a synchronizer before they are compared or returned as read data.

Top module: `pioc_detect`

## Requirements
- R1: While reset is asserted, `flag_o` and `irq_o` are 0.
- R2: When a monitored input pin changes away from its snapshot value, `flag_o` reads 1 by the third rising edge after the pin change (two synchronizer stages plus the flag register).
- R3: A one-cycle `flag_clr_i` pulse given while a difference persists leaves `flag_o` at 1, because setting wins over clearing.
- R4: A one-cycle `rd_stb_i` or `wr_stb_i` pulse loads all snapshot bits from the synchronized pins and does not itself change the flag. A clear given after that access sets `flag_o` to 0, and it stays 0 while the pins are stable.
- R5: The snapshot keeps its value through reset. If a difference exists when reset is released, `flag_o` is 1 after the first rising edge following release.
- R6: Only pins `MON_LSB` to `MON_LSB+MON_W-1` (bits 7:4 by default) are compared. A change on bits 3:0 never sets the flag.
- R7: A monitored pin takes part only while its `dir_i` bit is 1 (1 = input, 0 = output). Changes on a pin with `dir_i` = 0 do not set the flag.
- R8: In a cycle with a port access, the snapshot update takes priority: a difference that first appears in that cycle is absorbed and does not set the flag. A read also absorbs changes on every other pin.
- R9: `rd_data_o` returns all port bits as seen after the synchronizer, that is, the pin values from two rising edges earlier.
- R10: `irq_o` is 1 exactly when `flag_o` is 1 and `int_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the flag (the snapshot is not reset) |
| pin_i | input | PORT_W | Raw port pin levels |
| dir_i | input | PORT_W | Per-pin direction, 1 = input |
| rd_stb_i | input | 1 | Port read strobe, reloads the snapshot |
| wr_stb_i | input | 1 | Port write strobe, reloads the snapshot |
| rd_data_o | output | PORT_W | Synchronized pin values |
| flag_clr_i | input | 1 | Software clear of the change flag |
| int_en_i | input | 1 | Interrupt enable |
| flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions check on every cycle that an unabsorbed difference sets the flag on the next edge, that the flag holds until a clear, that a clear with no pending set succeeds, and that the snapshot loads only on an access and otherwise stays unchanged. They also check that an access cycle never raises a clear flag, and that the interrupt stays low while disabled. Only the bench scenarios can show the cycle-accurate latency through the synchronizer, the masking of the low pins and of output-direction pins, and the snapshot surviving reset. The same is true of the race in which a read lands in the exact cycle a change first reaches the comparator.

// File: rtl/pioc_pkg.sv
package pioc_pkg;
    typedef struct packed {
        logic flag;
    } pioc_flag_t;
endpackage

// File: rtl/pioc_sync.sv
module pioc_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    // data-path flops, intentionally without reset
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) stage_q[0] <= async_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pioc_cmp.sv
module pioc_cmp #(
    parameter int W       = 8,
    parameter int MON_LSB = 4,
    parameter int MON_W   = 4
) (
    input  logic [W-1:0] pins_i,
    input  logic [W-1:0] snap_i,
    input  logic [W-1:0] dir_i,
    output logic         mismatch_o
);
    logic [W-1:0] mon_mask;
    logic [W-1:0] diff;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mon_mask[g] = (g >= MON_LSB) && (g < MON_LSB + MON_W);
    end

    assign diff       = (pins_i ^ snap_i) & mon_mask & dir_i;
    assign mismatch_o = |diff;
endmodule

// File: rtl/pioc_core.sv
module pioc_core
    import pioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         mismatch_i,
    input  logic         rd_stb_i,
    input  logic         wr_stb_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] snap_o,
    output logic         flag_o
);
    pioc_flag_t   st_d, st_q;
    logic [W-1:0] snap_d, snap_q;
    logic         access, set_req;

    always_comb begin
        access  = rd_stb_i | wr_stb_i;
        set_req = mismatch_i & ~access;     // latch update wins over detection
        snap_d  = access ? pins_i : snap_q;
        st_d    = st_q;
        if (flag_clr_i) st_d.flag = 1'b0;
        if (set_req)    st_d.flag = 1'b1;   // set beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // snapshot sits outside the reset network
    always_ff @(posedge clk) snap_q <= snap_d;

    assign snap_o = snap_q;
    assign flag_o = st_q.flag;

    a_r2_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_i && !rd_stb_i && !wr_stb_i) |=> flag_o);
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);
    a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(mismatch_i && !rd_stb_i && !wr_stb_i)) |=> !flag_o);
    a_r4_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i || wr_stb_i) |=> (snap_o == $past(pins_i)));
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb_i && !wr_stb_i) |=> $stable(snap_o));
    a_r8_access_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb_i || wr_stb_i) && !flag_o) |=> !flag_o);
endmodule

// File: rtl/pioc_detect.sv
module pioc_detect #(
    parameter int PORT_W      = 8,
    parameter int MON_LSB     = 4,
    parameter int MON_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] dir_i,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    output logic [PORT_W-1:0] rd_data_o,
    input  logic              flag_clr_i,
    input  logic              int_en_i,
    output logic              flag_o,
    output logic              irq_o
);
    logic [PORT_W-1:0] pins_s, snap;
    logic              mismatch;

    pioc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .async_i(pin_i), .sync_o(pins_s)
    );

    pioc_cmp #(.W(PORT_W), .MON_LSB(MON_LSB), .MON_W(MON_W)) u_cmp (
        .pins_i(pins_s), .snap_i(snap), .dir_i(dir_i), .mismatch_o(mismatch)
    );

    pioc_core #(.W(PORT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_s), .mismatch_i(mismatch),
        .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .flag_clr_i(flag_clr_i),
        .snap_o(snap), .flag_o(flag_o)
    );

    assign rd_data_o = pins_s;
    assign irq_o     = flag_o & int_en_i;

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_i |-> !irq_o);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!flag_o && !irq_o));
endmodule

// File: tb/pioc_detect_tb.sv
module pioc_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin = '0, dir = 8'hFF, rd_data;
    logic       rd = 1'b0, wr = 1'b0, clr = 1'b0, en = 1'b1;
    logic       flag, irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    pioc_detect dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir),
        .rd_stb_i(rd), .wr_stb_i(wr), .rd_data_o(rd_data),
        .flag_clr_i(clr), .int_en_i(en), .flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_rd();  rd = 1'b1;  tick(1); rd = 1'b0;  endtask
    task automatic do_wr();  wr = 1'b1;  tick(1); wr = 1'b0;  endtask
    task automatic do_clr(); clr = 1'b1; tick(1); clr = 1'b0; endtask

    task automatic t_reset();   // R1
        tick(4);
        chk("R1 flag in reset", {7'd0, flag}, 8'd0);
        chk("R1 irq in reset", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;
        do_wr();
        do_clr();
        tick(2);
        chk("R1 flag quiet after sync", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_set();     // R2, R9
        pin[5] = 1'b1;
        tick(1);
        chk("R9 no data after 1 edge", rd_data, 8'h00);
        tick(1);
        chk("R9 data after 2 edges", rd_data, 8'h20);
        chk("R2 flag low before 3rd edge", {7'd0, flag}, 8'd0);
        tick(1);
        chk("R2 flag set", {7'd0, flag}, 8'd1);
    endtask

    task automatic t_sticky();  // R3
        do_clr();
        chk("R3 clear ignored in mismatch", {7'd0, flag}, 8'd1);
        tick(3);
        chk("R3 flag still set", {7'd0, flag}, 8'd1);
    endtask

    task automatic t_access();  // R4
        do_rd();
        chk("R4 read leaves flag", {7'd0, flag}, 8'd1);
        do_clr();
        chk("R4 clear after read", {7'd0, flag}, 8'd0);
        tick(5);
        chk("R4 stays low", {7'd0, flag}, 8'd0);
        pin[6] = 1'b1;
        tick(3);
        chk("R4 flag from pin 6", {7'd0, flag}, 8'd1);
        do_wr();
        do_clr();
        tick(3);
        chk("R4 clear after write", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_unmon();   // R6, R9
        pin[3:0] = 4'hA;
        tick(5);
        chk("R6 low pins ignored", {7'd0, flag}, 8'd0);
        chk("R9 low pins readable", rd_data, 8'h6A);
    endtask

    task automatic t_dir();     // R7
        dir[7] = 1'b0;
        pin[7] = 1'b1;
        tick(5);
        chk("R7 output pin ignored", {7'd0, flag}, 8'd0);
        dir[7] = 1'b1;
        tick(1);
        chk("R7 input pin compared", {7'd0, flag}, 8'd1);
        do_rd(); do_clr();
        chk("R7 cleanup", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_race();    // R8
        pin[4] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        tick(4);
        chk("R8 change absorbed by read", {7'd0, flag}, 8'd0);
        pin[4] = 1'b0;
        tick(3);
        chk("R8 pin 4 flags", {7'd0, flag}, 8'd1);
        pin[5] = 1'b0;
        tick(3);
        do_rd(); do_clr();
        tick(3);
        chk("R8 second pin absorbed", {7'd0, flag}, 8'd0);
    endtask

    task automatic t_irq();     // R10
        en = 1'b0;
        pin[4] = 1'b1;
        tick(3);
        chk("R10 flag set while disabled", {7'd0, flag}, 8'd1);
        chk("R10 irq gated", {7'd0, irq}, 8'd0);
        en = 1'b1;
        #1;
        chk("R10 irq enabled", {7'd0, irq}, 8'd1);
    endtask

    task automatic t_keep();    // R5
        rst_n = 1'b0;
        #1;
        chk("R5 flag cleared by reset", {7'd0, flag}, 8'd0);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R5 mismatch survives reset", {7'd0, flag}, 8'd1);
        do_rd(); do_clr();
        chk("R5 cleanup", {7'd0, flag}, 8'd0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_set();
        t_sticky();
        t_access();
        t_unmon();
        t_dir();
        t_race();
        t_irq();
        t_keep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule